// File: doc/BRIEF.md
# Offset-Cancelling Measurement Sequencer

This block drives a shared signed 12-bit converter through a fixed sweep of four analog channels: the lower cell voltage, the upper cell voltage, the pack current and the thermistor divider. Every reading takes two conversions. For the voltage and current channels the first conversion is taken with the amplifier inputs shorted, which gives the offset, and the second with the signal applied. For the thermistor the divider is driven first from the high reference and then from analog ground. The block subtracts the two codes in the order each channel needs. It saturates the difference to 13 signed bits and stores it in a result register for that channel. The converter is modelled as a request/valid handshake. The block presents the channel, the step and the amplifier gain (x4 for current, x1 otherwise) while its request is high.

When charging begins, the controller arms a bias capture. The next current difference is then kept as the current-sense bias and is taken off every later current reading. A second function recalibrates the voltage thresholds, which are held as converter codes. Given the measured code of a precise 4.2 V source, each threshold is scaled by the ratio of that code to the nominal 4.2 V code (1654). The scaling runs on one sequential divider, one threshold after another. All thresholds switch to their new values together when the divider work ends.

Top module: `meas_seq`

## Requirements
- R1: A `start` pulse while no sweep is running begins a sweep. A `start` during a sweep has no effect. `adc_req` stays high, with `adc_chan` and `adc_step` steady, until `adc_valid` is seen. After the sweep `adc_req` is low.
- R2: A sweep requests channels in the order 0 (cell 1), 1 (cell 2), 2 (current), 3 (thermistor). For each channel it requests step 0 (shorted inputs, or the high reference for the thermistor) and then step 1 (the signal, or analog ground for the thermistor).
- R3: `adc_gain_x4` is 1 while channel 2 is requested and 0 for every other channel.
- R4: The results for channels 0 and 1 equal the step-1 code minus the step-0 code. Both codes are sign-extended, giving a 13-bit signed result.
- R5: The thermistor result equals the step-0 code minus the step-1 code.
- R6: After a `bias_arm` pulse, the next current difference (step 1 minus step 0) is stored as the bias and that reading's result is 0. Every later current result is the difference minus the stored bias, saturated to the range -4096 to 4095.
- R7: `sweep_done` is high for exactly one cycle. It rises in the cycle after the thermistor step-1 code is accepted, and all four results are already updated in that cycle.
- R8: After reset all results are 0, `adc_req`, `sweep_done` and `cal_busy` are 0, and the thresholds are 1654 (slot 0, bits 11:0) and 1615 (slot 1, bits 23:12).
- R9: A `cal_start` while `cal_busy` is low raises `cal_busy` and latches `cal_code`. Each threshold becomes floor(old * cal_code / 1654), capped at 4095. `thr_out` does not change while `cal_busy` is high, and every slot changes in the cycle in which `cal_busy` falls. A `cal_start` while busy is ignored.
- R10: A sweep and a calibration may run at the same time, and each produces the same outputs it would produce alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one four-channel sweep |
| bias_arm | input | 1 | Take the next current difference as the bias |
| adc_req | output | 1 | Conversion requested |
| adc_chan | output | 2 | Channel to convert |
| adc_step | output | 1 | 0 = zero/reference step, 1 = signal step |
| adc_gain_x4 | output | 1 | Amplifier gain select, 1 = x4 |
| adc_valid | input | 1 | Conversion code is present |
| adc_code | input | 12 | Signed conversion code |
| res_cell1 | output | 13 | Cell 1 result |
| res_cell2 | output | 13 | Cell 2 result |
| res_curr | output | 13 | Current result with the bias removed |
| res_temp | output | 13 | Thermistor result |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |
| cal_start | input | 1 | Begin threshold recalibration |
| cal_code | input | 12 | Measured code of the 4.2 V source |
| cal_busy | output | 1 | Recalibration in progress |
| thr_out | output | 24 | Thresholds, slot 0 in the low bits |

## Verification
The sweep state machine and the calibration divider share one next-state process. A result write or the `sweep_done` pulse can therefore fall in the same cycle as a divider step or the threshold commit. The bench starts a sweep and a calibration in one fork, so that the two overlap. It checks every result against its own subtraction model and the thresholds against a floor-and-cap model. It also places a rejected `cal_start` and a rejected `start` inside the busy windows. It judges them at the ports: the later results and thresholds must match those of the first request alone.

// File: rtl/meas_pkg.sv
package meas_pkg;
    localparam int CODE_W = 12;
    localparam int RES_W  = CODE_W + 1;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int RES_MAX = (2 ** (RES_W - 1)) - 1;
    localparam int RES_MIN = -(2 ** (RES_W - 1));

    localparam logic [CH_W-1:0] CH_CELL1 = 2'd0;
    localparam logic [CH_W-1:0] CH_CELL2 = 2'd1;
    localparam logic [CH_W-1:0] CH_CUR   = 2'd2;
    localparam logic [CH_W-1:0] CH_TEMP  = 2'd3;

    typedef logic signed [CODE_W-1:0] code_t;
    typedef logic signed [RES_W-1:0]  res_t;
    typedef logic signed [RES_W:0]    wide_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REF, ST_SIG} seq_st_e;

    function automatic res_t sat_res(input wide_t v);
        if (v > wide_t'(RES_MAX))      return res_t'(RES_MAX);
        else if (v < wide_t'(RES_MIN)) return res_t'(RES_MIN);
        else                           return res_t'(v);
    endfunction
endpackage

// File: rtl/meas_diff.sv
module meas_diff
    import meas_pkg::*;
(
    input  code_t first,
    input  code_t second,
    input  logic  flip,
    input  logic  use_bias,
    input  res_t  bias,
    output res_t  raw,
    output res_t  res
);
    wide_t wide;

    always_comb begin
        if (flip) raw = res_t'(first) - res_t'(second);
        else      raw = res_t'(second) - res_t'(first);
        wide = wide_t'(raw) - (use_bias ? wide_t'(bias) : wide_t'(0));
        res  = sat_res(wide);
    end
endmodule

// File: rtl/cal_div.sv
module cal_div #(
    parameter int          PW      = 24,
    parameter int          DW      = 12,
    parameter int unsigned DIVISOR = 1654
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [PW-1:0] dividend,
    output logic          done,
    output logic [PW-1:0] quot
);
    localparam int CNTW = $clog2(PW + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CNTW-1:0] cnt;
        logic [PW-1:0]   dvd;
        logic [DW-1:0]   rem;
        logic [PW-1:0]   q;
    } div_s;

    div_s q_q, d_d;
    logic [DW:0] trial_d;
    logic [DW:0] less_d;

    always_comb begin
        d_d      = q_q;
        d_d.done = 1'b0;
        trial_d  = {q_q.rem, q_q.dvd[PW-1]};
        less_d   = trial_d - (DW+1)'(DIVISOR);
        if (go) begin
            d_d.busy = 1'b1;
            d_d.dvd  = dividend;
            d_d.rem  = '0;
            d_d.q    = '0;
            d_d.cnt  = CNTW'(PW);
        end else if (q_q.busy) begin
            if (trial_d >= (DW+1)'(DIVISOR)) begin
                d_d.rem = less_d[DW-1:0];
                d_d.q   = {q_q.q[PW-2:0], 1'b1};
            end else begin
                d_d.rem = trial_d[DW-1:0];
                d_d.q   = {q_q.q[PW-2:0], 1'b0};
            end
            d_d.dvd = q_q.dvd << 1;
            d_d.cnt = q_q.cnt - 1'b1;
            if (q_q.cnt == CNTW'(1)) begin
                d_d.busy = 1'b0;
                d_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= d_d;
    end

    assign done = q_q.done;
    assign quot = q_q.q;

    // R9: the controller never restarts the divider mid-division
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !q_q.busy);
endmodule

// File: rtl/meas_seq.sv
module meas_seq
    import meas_pkg::*;
#(
    parameter int                              NTHR     = 2,
    parameter int unsigned                     NOM_CODE = 1654,
    parameter logic [NTHR*meas_pkg::CODE_W-1:0] THR_INIT = {12'd1615, 12'd1654}
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                bias_arm,
    output logic                                adc_req,
    output logic [meas_pkg::CH_W-1:0]           adc_chan,
    output logic                                adc_step,
    output logic                                adc_gain_x4,
    input  logic                                adc_valid,
    input  logic signed [meas_pkg::CODE_W-1:0]  adc_code,
    output logic signed [meas_pkg::RES_W-1:0]   res_cell1,
    output logic signed [meas_pkg::RES_W-1:0]   res_cell2,
    output logic signed [meas_pkg::RES_W-1:0]   res_curr,
    output logic signed [meas_pkg::RES_W-1:0]   res_temp,
    output logic                                sweep_done,
    input  logic                                cal_start,
    input  logic [meas_pkg::CODE_W-1:0]         cal_code,
    output logic                                cal_busy,
    output logic [NTHR*meas_pkg::CODE_W-1:0]    thr_out
);
    localparam int PW   = 2 * CODE_W;
    localparam int IW   = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int TMAX = (2 ** CODE_W) - 1;

    typedef struct packed {
        seq_st_e                      st;
        logic [CH_W-1:0]              chan;
        code_t                        first;
        logic                         done;
        res_t                         bias;
        logic                         arm;
        res_t [NCH-1:0]               res;
        logic                         cal_busy;
        logic [IW-1:0]                idx;
        logic [CODE_W-1:0]            code;
        logic                         div_go;
        logic [NTHR-1:0][CODE_W-1:0]  stage;
        logic [NTHR-1:0][CODE_W-1:0]  thr;
    } seq_s;

    seq_s q_q, d_d;

    res_t            raw_w, diff_w;
    logic            div_done_w;
    logic [PW-1:0]   quot_w;
    logic [PW-1:0]   dividend_w;
    logic [CODE_W-1:0] clip_w;

    meas_diff u_diff (
        .first   (q_q.first),
        .second  (adc_code),
        .flip    (q_q.chan == CH_TEMP),
        .use_bias(q_q.chan == CH_CUR),
        .bias    (q_q.bias),
        .raw     (raw_w),
        .res     (diff_w)
    );

    assign dividend_w = PW'(q_q.thr[q_q.idx]) * PW'(q_q.code);

    cal_div #(.PW(PW), .DW(CODE_W), .DIVISOR(NOM_CODE)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q_q.div_go),
        .dividend(dividend_w),
        .done    (div_done_w),
        .quot    (quot_w)
    );

    assign clip_w = (quot_w > PW'(TMAX)) ? CODE_W'(TMAX) : quot_w[CODE_W-1:0];

    always_comb begin
        d_d        = q_q;
        d_d.done   = 1'b0;
        d_d.div_go = 1'b0;

        // sweep sequencer
        case (q_q.st)
            ST_IDLE: if (start) begin
                d_d.st   = ST_REF;
                d_d.chan = CH_CELL1;
            end
            ST_REF: if (adc_valid) begin
                d_d.first = adc_code;
                d_d.st    = ST_SIG;
            end
            ST_SIG: if (adc_valid) begin
                if (q_q.chan == CH_CUR && q_q.arm) begin
                    d_d.bias         = raw_w;
                    d_d.res[q_q.chan] = '0;
                    d_d.arm          = 1'b0;
                end else begin
                    d_d.res[q_q.chan] = diff_w;
                end
                if (q_q.chan == CH_TEMP) begin
                    d_d.st   = ST_IDLE;
                    d_d.done = 1'b1;
                end else begin
                    d_d.chan = q_q.chan + 1'b1;
                    d_d.st   = ST_REF;
                end
            end
            default: d_d.st = ST_IDLE;
        endcase
        if (bias_arm) d_d.arm = 1'b1;

        // threshold calibration
        if (!q_q.cal_busy) begin
            if (cal_start) begin
                d_d.cal_busy = 1'b1;
                d_d.code     = cal_code;
                d_d.idx      = '0;
                d_d.div_go   = 1'b1;
            end
        end else if (div_done_w) begin
            d_d.stage[q_q.idx] = clip_w;
            if (q_q.idx == IW'(NTHR - 1)) begin
                d_d.thr      = d_d.stage;
                d_d.cal_busy = 1'b0;
            end else begin
                d_d.idx    = q_q.idx + 1'b1;
                d_d.div_go = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q     <= '0;
            q_q.st  <= ST_IDLE;
            q_q.thr <= THR_INIT;
        end else begin
            q_q <= d_d;
        end
    end

    assign adc_req     = (q_q.st != ST_IDLE);
    assign adc_step    = (q_q.st == ST_SIG);
    assign adc_chan    = q_q.chan;
    assign adc_gain_x4 = adc_req && (q_q.chan == CH_CUR);
    assign res_cell1   = q_q.res[CH_CELL1];
    assign res_cell2   = q_q.res[CH_CELL2];
    assign res_curr    = q_q.res[CH_CUR];
    assign res_temp    = q_q.res[CH_TEMP];
    assign sweep_done  = q_q.done;
    assign cal_busy    = q_q.cal_busy;
    assign thr_out     = q_q.thr;

    // R1: request held with steady channel and step until accepted
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_valid) |=> (adc_req && $stable(adc_chan) && $stable(adc_step)));

    // R2: leaving a signal step moves on to the next channel
    a_r2_chan_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && $fell(adc_step)) |-> (adc_chan == $past(adc_chan) + 1'b1));

    // R7: accepted thermistor signal code yields the done pulse next cycle
    a_r7_done_after_temp: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_step && adc_valid && adc_chan == CH_TEMP) |=> sweep_done);

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

    // R9: thresholds move only in the cycle calibration ends
    a_r9_thr_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_out) |-> (!cal_busy && $past(cal_busy)));
endmodule

// File: tb/tb_meas_seq.sv
module tb_meas_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NOM = 1654;
    localparam int ROWS = 4;
    // per row: c1 off, c1 sig, c2 off, c2 sig, cur off, cur sig, t hi, t gnd, arm
    localparam int VEC [ROWS][9] = '{
        '{   10, 1664,   -5, 1600,     3,   40,  1900,   800, 1},
        '{-2048, 2047, 2047,-2048,     0,  100, -2048,  2047, 0},
        '{    0,    0,  100,  100, -2048, 2047,  2047, -2048, 1},
        '{    7,    3,    1,    2,  2047,-2048,     5,     5, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, bias_arm = 1'b0, adc_valid = 1'b0, cal_start = 1'b0;
    logic signed [11:0] adc_code = '0;
    logic [11:0] cal_code = '0;
    logic adc_req, adc_step, adc_gain_x4, sweep_done, cal_busy;
    logic [1:0] adc_chan;
    logic signed [12:0] res_cell1, res_cell2, res_curr, res_temp;
    logic [23:0] thr_out;

    int total = 0, bad = 0;
    int bias_m = 0;
    int thr_m [2] = '{1654, 1615};

    always #(CLK_PERIOD/2) clk = ~clk;

    meas_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bias_arm(bias_arm),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_step(adc_step),
        .adc_gain_x4(adc_gain_x4), .adc_valid(adc_valid), .adc_code(adc_code),
        .res_cell1(res_cell1), .res_cell2(res_cell2), .res_curr(res_curr),
        .res_temp(res_temp), .sweep_done(sweep_done), .cal_start(cal_start),
        .cal_code(cal_code), .cal_busy(cal_busy), .thr_out(thr_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat13(input int v);
        if (v > 4095) return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    task automatic run_sweep(input int r, input bit poke);
        int exp_res [4];
        if (VEC[r][8] != 0) begin
            @(negedge clk); bias_arm = 1'b1;
            @(negedge clk); bias_arm = 1'b0;
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 50 && !adc_req; w++) @(negedge clk);
            check("R2 channel", int'(adc_chan), s / 2);
            check("R2 step", int'(adc_step), s % 2);
            check("R3 gain", int'(adc_gain_x4), (s / 2 == 2) ? 1 : 0);
            if (poke && s == 3) start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk);
            check("R1 held", int'(adc_req), 1);
            adc_code = 12'(VEC[r][s]);
            adc_valid = 1'b1;
            @(negedge clk); adc_valid = 1'b0;
        end
        exp_res[0] = VEC[r][1] - VEC[r][0];
        exp_res[1] = VEC[r][3] - VEC[r][2];
        if (VEC[r][8] != 0) begin
            bias_m = VEC[r][5] - VEC[r][4];
            exp_res[2] = 0;
        end else begin
            exp_res[2] = sat13(VEC[r][5] - VEC[r][4] - bias_m);
        end
        exp_res[3] = VEC[r][6] - VEC[r][7];
        check("R7 done", int'(sweep_done), 1);
        check("R4 cell1", int'(res_cell1), exp_res[0]);
        check("R4 cell2", int'(res_cell2), exp_res[1]);
        check("R6 current", int'(res_curr), exp_res[2]);
        check("R5 temp", int'(res_temp), exp_res[3]);
        @(negedge clk);
        check("R7 single", int'(sweep_done), 0);
        @(negedge clk);
        check("R1 idle after sweep", int'(adc_req), 0);
    endtask

    task automatic run_cal(input int code);
        int old0 = thr_m[0];
        int old1 = thr_m[1];
        @(negedge clk); cal_start = 1'b1; cal_code = 12'(code);
        @(negedge clk); cal_start = 1'b0;
        check("R9 busy", int'(cal_busy), 1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        cal_start = 1'b1; cal_code = 12'd1;
        @(negedge clk); cal_start = 1'b0;
        check("R9 hold0", int'(thr_out[11:0]), old0);
        check("R9 hold1", int'(thr_out[23:12]), old1);
        for (int w = 0; w < 500 && cal_busy; w++) @(negedge clk);
        thr_m[0] = (old0 * code) / NOM; if (thr_m[0] > 4095) thr_m[0] = 4095;
        thr_m[1] = (old1 * code) / NOM; if (thr_m[1] > 4095) thr_m[1] = 4095;
        check("R9 thr0", int'(thr_out[11:0]), thr_m[0]);
        check("R9 thr1", int'(thr_out[23:12]), thr_m[1]);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R9 ignored start", int'(cal_busy), 0);
    endtask

    initial begin
        for (int i = 0; i < CLK_PERIOD * 150000; i++) #1;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 req", int'(adc_req), 0);
        check("R8 done", int'(sweep_done), 0);
        check("R8 busy", int'(cal_busy), 0);
        check("R8 cell1", int'(res_cell1), 0);
        check("R8 current", int'(res_curr), 0);
        check("R8 thr0", int'(thr_out[11:0]), 1654);
        check("R8 thr1", int'(thr_out[23:12]), 1615);
        for (int r = 0; r < ROWS; r++) run_sweep(r, r == 1);
        run_cal(1700);
        run_cal(4095);
        fork
            run_sweep(0, 1'b0);
            run_cal(1000);
        join
        check("R10 thr0 after overlap", int'(thr_out[11:0]), thr_m[0]);
        check("R10 temp after overlap", int'(res_temp), VEC[0][6] - VEC[0][7]);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule